// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block is a single acceptance filter bank for a CAN receive path. It keeps two 32-bit configuration words and compares them against the identifier fields of the frame being received: the 11-bit base identifier, the 18-bit identifier extension, the extended-format flag and the remote-request flag. A scale bit decides whether the two words form wide filters that see the whole identifier, or narrow half-word filters that see the base identifier, both flags and the top three extension bits. A mode bit decides whether the words are used as identifier-plus-care-mask pairs or as a list of exact identifiers.

Depending on these two bits, one bank provides one, two or four filters. The bank drives one hit flag per filter for the frame now on its inputs. It also reports how many filter numbers it occupies, so a surrounding receiver can number filters across several banks. Merging hits across banks, frame decoding and storage sit outside this block.

A write port loads the two words and a control word that holds an enable, the scale and the mode. Scale and mode are frozen while the bank is enabled.

Top module: `can_acf_bank`

## Requirements
- R1: After reset both words are zero, the bank is disabled, the scale is narrow and the mode is mask. So `hit_vec` is 0 and `flt_count` is 2.
- R2: A write with `cfg_addr` 0 loads word A, `cfg_addr` 1 loads word B and `cfg_addr` 2 loads control. In the control word, bit 0 is the enable, bit 1 is the scale (1 = wide) and bit 2 is the mode (1 = list). A write with `cfg_addr` 3 changes nothing.
- R3: In wide mask mode there is one filter (flag 0). Its key is {base[10:0], ext[17:0], ide, rtr, 0}, with the base identifier at bits 31:21, the extension at 20:3, ide at 2 and rtr at 1. Word A is the pattern and word B the care mask (1 = must be equal, 0 = ignored). Bit 0 never takes part in a comparison.
- R4: In wide list mode, flag 0 is set when bits 31:1 of the key equal word A exactly, and flag 1 when they equal word B exactly.
- R5: The narrow key is {base[10:0], rtr, ide, ext[17:15]}. In narrow mask mode there are two filters. Flag 0 uses pattern A[15:0] with care mask A[31:16]. Flag 1 uses pattern B[15:0] with care mask B[31:16].
- R6: In narrow list mode there are four exact filters. Flag 0 compares with A[15:0], flag 1 with A[31:16], flag 2 with B[15:0] and flag 3 with B[31:16]. Several flags may be set at once.
- R7: While the bank is disabled, `hit_vec` is 0 whatever the identifier and the words hold.
- R8: A control write made while the bank is enabled leaves scale and mode unchanged, but its enable bit still takes effect.
- R9: `flt_count` is 1 for wide mask, 2 for wide list, 2 for narrow mask and 4 for narrow list. Flags at or above that count are always 0.
- R10: `hit_vec` follows the identifier inputs within the same cycle. A configuration write changes `hit_vec` and `flt_count` from the clock edge that takes it. Words A and B can be written while the bank is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write target: 0 word A, 1 word B, 2 control |
| cfg_wdata | input | 32 | Write data |
| rx_base | input | 11 | Base identifier of the current frame |
| rx_ext | input | 18 | Identifier extension of the current frame |
| rx_ide | input | 1 | Extended-format flag of the current frame |
| rx_rtr | input | 1 | Remote-request flag of the current frame |
| hit_vec | output | 4 | Per-filter hit flags |
| flt_count | output | 3 | Number of filters the bank occupies |

## Verification
The bench builds a frame that matches both words at once in wide mask mode. A design that treated word B as a second filter would raise flag 1 there, although the bank provides only one filter in that mode. Bit 0 of both words is set in a wide case so that a comparison that wrongly included the reserved bit would drop a valid hit. In the narrow cases the extension bits below 15 are set to non-zero values, so a key built from the wrong slice of the extension misses. One narrow list case matches two filters at once, so a one-hot encoder in place of a flag vector loses a flag. A control write tries to change scale and mode while the bank is enabled, and `flt_count` shows whether that write slipped through.

// File: rtl/can_acf_pkg.sv
package can_acf_pkg;
  localparam int BASE_W  = 11;
  localparam int EXT_W   = 18;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int NFLT    = 4;
  localparam int CNT_W   = $clog2(NFLT) + 1;
  localparam int NARROW_EXT = 3;

  localparam logic [1:0] ADDR_WA  = 2'd0;
  localparam logic [1:0] ADDR_WB  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  localparam int CTL_EN    = 0;
  localparam int CTL_WIDE  = 1;
  localparam int CTL_LIST  = 2;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
    logic              ide;
    logic              rtr;
  } rx_id_t;
endpackage

// File: rtl/can_acf_cfg.sv
module can_acf_cfg
  import can_acf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic              en,
  output logic              wide,
  output logic              list
);
  logic [WORD_W-1:0] wa_q, wa_d, wb_q, wb_d;
  logic en_q, en_d, wide_q, wide_d, list_q, list_d;

  // next-state: shape bits only move while the bank is disabled
  always_comb begin
    wa_d   = wa_q;
    wb_d   = wb_q;
    en_d   = en_q;
    wide_d = wide_q;
    list_d = list_q;
    if (we) begin
      case (addr)
        ADDR_WA:  wa_d = wdata;
        ADDR_WB:  wb_d = wdata;
        ADDR_CTL: begin
          en_d = wdata[CTL_EN];
          if (!en_q) begin
            wide_d = wdata[CTL_WIDE];
            list_d = wdata[CTL_LIST];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q   <= '0;
      wb_q   <= '0;
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      list_q <= 1'b0;
    end else begin
      wa_q   <= wa_d;
      wb_q   <= wb_d;
      en_q   <= en_d;
      wide_q <= wide_d;
      list_q <= list_d;
    end
  end

  assign word_a = wa_q;
  assign word_b = wb_q;
  assign en     = en_q;
  assign wide   = wide_q;
  assign list   = list_q;

  // R8: an enabled bank keeps its scale and mode across the next edge
  p_shape_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable({wide_q, list_q}));

  // R2: a write to the reserved address changes nothing
  p_reserved_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd3) |=> $stable({wa_q, wb_q, en_q, wide_q, list_q}));
endmodule

// File: rtl/can_acf_cmp.sv
module can_acf_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] key,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] care,
  output logic         hit
);
  logic [W-1:0] diff;

  always_comb begin
    diff = (key ^ pat) & care;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/can_acf_sel.sv
module can_acf_sel
  import can_acf_pkg::*;
(
  input  logic             en,
  input  logic             wide,
  input  logic             list,
  input  logic [1:0]       wide_hit,
  input  logic [NFLT-1:0]  narrow_hit,
  output logic [NFLT-1:0]  hits,
  output logic [CNT_W-1:0] count
);
  logic [NFLT-1:0] raw;

  always_comb begin
    raw = '0;
    if (wide) begin
      raw[0] = wide_hit[0];
      raw[1] = list & wide_hit[1];
      count  = list ? CNT_W'(2) : CNT_W'(1);
    end else begin
      raw[1:0] = narrow_hit[1:0];
      if (list) raw[NFLT-1:2] = narrow_hit[NFLT-1:2];
      count    = list ? CNT_W'(4) : CNT_W'(2);
    end
    hits = en ? raw : '0;
  end
endmodule

// File: rtl/can_acf_bank.sv
module can_acf_bank
  import can_acf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [10:0] rx_base,
  input  logic [17:0] rx_ext,
  input  logic        rx_ide,
  input  logic        rx_rtr,
  output logic [3:0]  hit_vec,
  output logic [2:0]  flt_count
);
  localparam int NWIDE = 2;
  localparam logic [WORD_W-1:0] RSV_OFF = {{(WORD_W-1){1'b1}}, 1'b0};

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [WORD_W-1:0] word_a, word_b;
  logic              cfg_en, cfg_wide, cfg_list;

  can_acf_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .word_a (word_a),
    .word_b (word_b),
    .en     (cfg_en),
    .wide   (cfg_wide),
    .list   (cfg_list)
  );

  rx_id_t            rx;
  logic [WORD_W-1:0] key_w;
  logic [HALF_W-1:0] key_n;

  always_comb begin
    rx.base = rx_base;
    rx.ext  = rx_ext;
    rx.ide  = rx_ide;
    rx.rtr  = rx_rtr;
    key_w   = {rx, 1'b0};
    key_n   = {rx.base, rx.rtr, rx.ide, rx.ext[EXT_W-1 -: NARROW_EXT]};
  end

  // wide filters: pattern and care per filter
  logic [WORD_W-1:0] w_pat  [NWIDE];
  logic [WORD_W-1:0] w_care [NWIDE];
  logic [NWIDE-1:0]  w_hit;

  always_comb begin
    w_pat[0]  = word_a;
    w_care[0] = (cfg_list ? '1 : word_b) & RSV_OFF;
    w_pat[1]  = word_b;
    w_care[1] = RSV_OFF;
  end

  // narrow filters: halves in order A.lo, A.hi, B.lo, B.hi
  logic [HALF_W-1:0] half [NFLT];
  logic [HALF_W-1:0] n_pat  [NFLT];
  logic [HALF_W-1:0] n_care [NFLT];
  logic [NFLT-1:0]   n_hit;

  always_comb begin
    half[0] = word_a[HALF_W-1:0];
    half[1] = word_a[WORD_W-1:HALF_W];
    half[2] = word_b[HALF_W-1:0];
    half[3] = word_b[WORD_W-1:HALF_W];
    for (int i = 0; i < NFLT; i++) begin
      n_pat[i]  = half[i];
      n_care[i] = '1;
    end
    if (!cfg_list) begin
      n_pat[0]  = half[0];
      n_care[0] = half[1];
      n_pat[1]  = half[2];
      n_care[1] = half[3];
    end
  end

  for (genvar g = 0; g < NWIDE; g++) begin : g_wide
    can_acf_cmp #(.W(WORD_W)) u_cmp (
      .key  (key_w),
      .pat  (w_pat[g]),
      .care (w_care[g]),
      .hit  (w_hit[g])
    );
  end

  for (genvar g = 0; g < NFLT; g++) begin : g_narrow
    can_acf_cmp #(.W(HALF_W)) u_cmp (
      .key  (key_n),
      .pat  (n_pat[g]),
      .care (n_care[g]),
      .hit  (n_hit[g])
    );
  end

  can_acf_sel u_sel (
    .en         (cfg_en),
    .wide       (cfg_wide),
    .list       (cfg_list),
    .wide_hit   (w_hit),
    .narrow_hit (n_hit),
    .hits       (hit_vec),
    .count      (flt_count)
  );

  // R7: a disabled bank stays silent
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_en |-> hit_vec == 4'b0000);

  // R9: flags never reach past the occupied filter count
  p_hits_in_range_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hit_vec >> flt_count) == 4'b0000);

  // R9: the count is always one of 1, 2 or 4
  p_count_code_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $countones(flt_count) == 1 && flt_count != 3'd0);

  // R3: wide mask mode offers a single filter
  p_wide_mask_single_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (flt_count == 3'd1) |-> hit_vec[3:1] == 3'b000);
endmodule

// File: tb/can_acf_bank_tb.sv
module can_acf_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [10:0] rx_base = 11'd0;
  logic [17:0] rx_ext = 18'd0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic [3:0]  hit_vec;
  logic [2:0]  flt_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_acf_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_base(rx_base), .rx_ext(rx_ext),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .hit_vec(hit_vec), .flt_count(flt_count)
  );

  function automatic logic [31:0] mk32(logic [10:0] b, logic [17:0] e, logic i, logic r);
    return {b, e, i, r, 1'b0};
  endfunction

  function automatic logic [15:0] mk16(logic [10:0] b, logic r, logic i, logic [2:0] e3);
    return {b, r, i, e3};
  endfunction

  typedef struct packed {
    logic        list;
    logic        wide;
    logic [31:0] wa;
    logic [31:0] wb;
    logic [10:0] base;
    logic [17:0] ext;
    logic        ide;
    logic        rtr;
    logic [3:0]  exp_hit;
    logic [2:0]  exp_cnt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R3 wide mask, full care
    '{1'b0, 1'b1, mk32(11'h123, 18'h00ABC, 1'b1, 1'b0), 32'hFFFF_FFFE,
      11'h123, 18'h00ABC, 1'b1, 1'b0, 4'b0001, 3'd1},
    '{1'b0, 1'b1, mk32(11'h123, 18'h00ABC, 1'b1, 1'b0), 32'hFFFF_FFFE,
      11'h123, 18'h00ABD, 1'b1, 1'b0, 4'b0000, 3'd1},
    // R3 wide mask, base-only care
    '{1'b0, 1'b1, mk32(11'h123, 18'h0, 1'b1, 1'b0), 32'hFFE0_0000,
      11'h123, 18'h3FFFF, 1'b0, 1'b1, 4'b0001, 3'd1},
    '{1'b0, 1'b1, mk32(11'h123, 18'h0, 1'b1, 1'b0), 32'hFFE0_0000,
      11'h122, 18'h3FFFF, 1'b0, 1'b1, 4'b0000, 3'd1},
    // R4 wide list
    '{1'b1, 1'b1, mk32(11'h7FF, 18'h0, 1'b0, 1'b0), mk32(11'h001, 18'h3FFFF, 1'b1, 1'b1),
      11'h001, 18'h3FFFF, 1'b1, 1'b1, 4'b0010, 3'd2},
    '{1'b1, 1'b1, mk32(11'h7FF, 18'h0, 1'b0, 1'b0), mk32(11'h001, 18'h3FFFF, 1'b1, 1'b1),
      11'h7FF, 18'h0, 1'b0, 1'b0, 4'b0001, 3'd2},
    '{1'b1, 1'b1, mk32(11'h7FF, 18'h0, 1'b0, 1'b0), mk32(11'h001, 18'h3FFFF, 1'b1, 1'b1),
      11'h7FF, 18'h1, 1'b0, 1'b0, 4'b0000, 3'd2},
    // R5 narrow mask
    '{1'b0, 1'b0, {16'hFFFF, mk16(11'h055, 1'b0, 1'b0, 3'b101)},
      {16'hFFE0, mk16(11'h2AA, 1'b1, 1'b0, 3'b000)},
      11'h055, 18'h28123, 1'b0, 1'b0, 4'b0001, 3'd2},
    '{1'b0, 1'b0, {16'hFFFF, mk16(11'h055, 1'b0, 1'b0, 3'b101)},
      {16'hFFE0, mk16(11'h2AA, 1'b1, 1'b0, 3'b000)},
      11'h2AA, 18'h00000, 1'b1, 1'b0, 4'b0010, 3'd2},
    // R6 narrow list
    '{1'b1, 1'b0, {mk16(11'h200, 1'b1, 1'b0, 3'b000), mk16(11'h100, 1'b0, 1'b0, 3'b000)},
      {mk16(11'h100, 1'b0, 1'b0, 3'b000), mk16(11'h300, 1'b0, 1'b1, 3'b111)},
      11'h100, 18'h00042, 1'b0, 1'b0, 4'b1001, 3'd4},
    '{1'b1, 1'b0, {mk16(11'h200, 1'b1, 1'b0, 3'b000), mk16(11'h100, 1'b0, 1'b0, 3'b000)},
      {mk16(11'h100, 1'b0, 1'b0, 3'b000), mk16(11'h300, 1'b0, 1'b1, 3'b111)},
      11'h300, 18'h38000, 1'b1, 1'b0, 4'b0100, 3'd4},
    '{1'b1, 1'b0, {mk16(11'h200, 1'b1, 1'b0, 3'b000), mk16(11'h100, 1'b0, 1'b0, 3'b000)},
      {mk16(11'h100, 1'b0, 1'b0, 3'b000), mk16(11'h300, 1'b0, 1'b1, 3'b111)},
      11'h200, 18'h00000, 1'b0, 1'b1, 4'b0010, 3'd4},
    '{1'b1, 1'b0, {mk16(11'h200, 1'b1, 1'b0, 3'b000), mk16(11'h100, 1'b0, 1'b0, 3'b000)},
      {mk16(11'h100, 1'b0, 1'b0, 3'b000), mk16(11'h300, 1'b0, 1'b1, 3'b111)},
      11'h200, 18'h00000, 1'b0, 1'b0, 4'b0000, 3'd4},
    // R3 reserved bit 0 set in pattern and care
    '{1'b0, 1'b1, mk32(11'h0F0, 18'h12345, 1'b0, 1'b0) | 32'h1, 32'hFFFF_FFFF,
      11'h0F0, 18'h12345, 1'b0, 1'b0, 4'b0001, 3'd1},
    // R9 wide mask: frame equals word B too, still one flag
    '{1'b0, 1'b1, mk32(11'h3C3, 18'h15555, 1'b0, 1'b1), mk32(11'h3C3, 18'h15555, 1'b0, 1'b1),
      11'h3C3, 18'h15555, 1'b0, 1'b1, 4'b0001, 3'd1}
  };

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [3:0] exp_h, input logic [2:0] exp_c);
    n_cmp++;
    if (hit_vec !== exp_h || flt_count !== exp_c) begin
      n_bad++;
      $display("FAIL %s: hit=%b cnt=%0d expected hit=%b cnt=%0d",
               tag, hit_vec, flt_count, exp_h, exp_c);
    end
  endtask

  task automatic set_rx(input logic [10:0] b, input logic [17:0] e, input logic i, input logic r);
    rx_base = b; rx_ext = e; rx_ide = i; rx_rtr = r;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    set_rx(11'h0, 18'h0, 1'b0, 1'b0);
    chk("R1 reset state", 4'b0000, 3'd2);

    // R5 narrow mask with zero care: both filters pass once enabled
    wr(2'd2, 32'h1);
    chk("R5 zero care passes all", 4'b0011, 3'd2);

    // R8 shape write while enabled is ignored, enable kept
    wr(2'd2, 32'h7);
    chk("R8 shape locked while enabled", 4'b0011, 3'd2);

    // R7 disabled bank stays silent
    wr(2'd2, 32'h6);
    chk("R7 disabled no hits", 4'b0000, 3'd2);

    // R8 shape accepted while disabled
    wr(2'd2, 32'h4);
    chk("R8 shape accepted when idle", 4'b0000, 3'd4);

    // R2 reserved address has no effect
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R2 reserved address", 4'b0000, 3'd4);

    // R6/R10 narrow list, zero words, zero frame: all four hit
    wr(2'd2, 32'h5);
    chk("R6 four list hits", 4'b1111, 3'd4);

    // R10 word write while enabled: visible after the taking edge only
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0001_0000;
    #1;
    chk("R10 before write edge", 4'b1111, 3'd4);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk("R10 after write edge", 4'b1101, 3'd4);

    // R10 same-cycle response to identifier inputs
    set_rx(11'h001, 18'h0, 1'b0, 1'b0);
    chk("R10 combinational response", 4'b0000, 3'd4);

    // table walk: R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      wr(2'd2, 32'h0);
      wr(2'd2, {29'd0, VEC[k].list, VEC[k].wide, 1'b0});
      wr(2'd0, VEC[k].wa);
      wr(2'd1, VEC[k].wb);
      wr(2'd2, {29'd0, VEC[k].list, VEC[k].wide, 1'b1});
      @(negedge clk);
      set_rx(VEC[k].base, VEC[k].ext, VEC[k].ide, VEC[k].rtr);
      chk($sformatf("R3-R9 table vector %0d (R3 R4 R5 R6 R9)", k), VEC[k].exp_hit, VEC[k].exp_cnt);
    end

    // R7 after the last matching vector, disable again
    wr(2'd2, 32'h0);
    chk("R7 disable after match", 4'b0000, 3'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule